// File: doc/BRIEF.md
# Single-Precision to Narrow Float Converter

This block takes a 32-bit single-precision floating-point word and produces a narrower floating-point word whose layout is fixed at elaboration time by three parameters: the exponent width, the mantissa width, and whether the target has an infinity encoding. With those parameters it covers half precision (5/10, with infinity), bfloat16 (8/7, with infinity), an 8-bit 5/2 format with infinity, and an 8-bit 4/3 format that has no infinity and a single NaN encoding. A per-word input selects round-to-nearest-even or round-toward-zero.

The conversion is one combinational path. A parameter adds an output register, and that register gives exactly one cycle from `in_valid` to `out_valid`. The converter handles normal results, subnormal results, flush to signed zero, overflow, infinity and NaN, with the same logic for targets with and without infinity.

Top module: `fp32_narrow`

## Requirements
- R1: The target bias is 2^(EXP_W-1)-1. An in-range normal input is re-biased into the target exponent field, and its mantissa keeps the top MAN_W source mantissa bits before rounding. The output word is sign at bit EXP_W+MAN_W, then the exponent field, then the mantissa.
- R2: With `rne_mode`=1, the kept mantissa is incremented when the discarded bits exceed half an ULP. It is also incremented when they equal exactly half an ULP and the kept LSB is 1.
- R3: With `rne_mode`=0, discarded bits are dropped, so the result magnitude never exceeds the input magnitude. A finite input never yields infinity.
- R4: If rounding carries out of an all-ones mantissa, the mantissa clears and the exponent increments, so a target with infinity reaches infinity. On a target without infinity whose exponent field is already all ones, the result is instead exponent all ones with mantissa all ones.
- R5: An input below the target's minimum normal exponent, with a right-shift distance of at most MAN_W+1, gives a subnormal: exponent field 0, implicit one inserted, shifted and rounded. A carry from this rounding produces the minimum normal.
- R6: Inputs further below the target range give signed zero. Source subnormals give signed zero whenever the target's minimum exponent leaves none of them representable.
- R7: With `rne_mode`=1, an input whose exponent exceeds the target maximum gives signed infinity (exponent all ones, mantissa 0) on a target with infinity. On a target without infinity it gives exponent all ones with mantissa all ones. The target maximum unbiased exponent is the bias with infinity and the bias plus one without.
- R8: With `rne_mode`=0, a finite overflowing input gives the signed largest magnitude with mantissa all ones. Its exponent field is all ones minus one on a target with infinity, and all ones on a target without. An infinite input gives infinity on a target with infinity.
- R9: A NaN input keeps its sign. On a target with infinity, the output has exponent all ones, the top MAN_W payload bits, and the mantissa MSB forced to 1. On a target without infinity, the mantissa becomes all ones.
- R10: With REG_OUT=1, `out_valid` is 0 during reset and equals `in_valid` of the previous cycle. `out_data` holds the result of the word accepted in that cycle.
- R11: A zero input of either sign gives a zero of the same sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Single-precision input |
| rne_mode | input | 1 | 1 = round to nearest even, 0 = round toward zero |
| out_valid | output | 1 | Result is valid |
| out_data | output | 1+EXP_W+MAN_W | Converted word |

## Verification
The bench runs a half-precision instance and a 4/3 no-infinity instance side by side against a reference that works through significand and quantum arithmetic. It goes after exact ties on both sides of the even rule, where a wrong tie rule rounds 1+2^-11 up or 1+3·2^-11 down. It also drives mantissa carries into the exponent: a broken carry would return 65520 as a finite half, or would not yield the all-ones NaN for 496 on the no-infinity target. Subnormal boundaries, overflow saturation in truncate mode and signalling NaNs with low payload bits are covered too; a missing quiet bit would turn those NaNs into infinity.

// File: rtl/fp32_narrow.sv
module fp32_narrow #(
  parameter int EXP_W   = 5,
  parameter int MAN_W   = 10,
  parameter int HAS_INF = 1,
  parameter int REG_OUT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [31:0]              in_data,
  input  logic                     rne_mode,
  output logic                     out_valid,
  output logic [EXP_W+MAN_W:0]     out_data
);
  localparam int OW    = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int UMIN  = 1 - BIAS;
  localparam int UMAX  = (HAS_INF != 0) ? BIAS : BIAS + 1;
  localparam int DROP  = 23 - MAN_W;
  localparam bit FLUSH = (UMIN + 126) > DROP;
  localparam logic [EXP_W-1:0] EALL  = {EXP_W{1'b1}};
  localparam logic [MAN_W-1:0] MALL  = {MAN_W{1'b1}};
  localparam logic [MAN_W-1:0] QBIT  = {1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [DROP-1:0]  NHALF = {1'b1, {(DROP-1){1'b0}}};

  logic        s;
  logic [7:0]  se;
  logic [22:0] sm;
  logic        src_nan;
  assign s  = in_data[31];
  assign se = in_data[30:23];
  assign sm = in_data[22:0];
  assign src_nan = (se == 8'hFF) && (sm != '0);

  int ue, sh, tot;
  logic [24:0] mone, rem, half;
  logic [EXP_W+MAN_W-1:0] kept;
  logic [EXP_W-1:0] ne;
  logic [MAN_W-1:0] nm;
  logic [DROP-1:0]  nrem;
  logic [OW-1:0]    res;

  always_comb begin
    ue   = int'(se) - 127;
    sh   = 0;
    tot  = 0;
    mone = '0;
    rem  = '0;
    half = '0;
    kept = '0;
    ne   = '0;
    nm   = '0;
    nrem = '0;
    res  = {s, {(OW-1){1'b0}}};
    if (ue < UMIN) begin
      if (!(FLUSH && se == 8'd0)) begin
        sh = UMIN - ue;
        if (sh <= MAN_W + 1) begin
          mone = {1'b0, (FLUSH || se != 8'd0), sm};
          if (!FLUSH && se == 8'd0) sh = sh - 1;
          tot  = DROP + sh;
          kept = (EXP_W+MAN_W)'(mone >> tot);
          rem  = mone & ((25'd1 << tot) - 25'd1);
          half = 25'd1 << (tot - 1);
          if (rne_mode && (rem > half || (rem == half && kept[0])))
            kept = kept + 1'b1;
          res = {s, kept};
        end
      end
    end else if (ue > UMAX) begin
      if (src_nan) begin
        if (HAS_INF != 0) res = {s, EALL, sm[22 -: MAN_W] | QBIT};
        else              res = {s, EALL, MALL};
      end else if (!rne_mode && !((HAS_INF != 0) && se == 8'hFF)) begin
        res = {s, EALL - EXP_W'(HAS_INF), MALL};
      end else begin
        if (HAS_INF != 0) res = {s, EALL, {MAN_W{1'b0}}};
        else              res = {s, EALL, MALL};
      end
    end else begin
      ne   = EXP_W'(ue + BIAS);
      nm   = sm[22 -: MAN_W];
      nrem = sm[DROP-1:0];
      if (rne_mode && (nrem > NHALF || (nrem == NHALF && nm[0]))) begin
        if (nm != MALL) begin
          nm = nm + 1'b1;
        end else if ((HAS_INF != 0) || ne != EALL) begin
          nm = '0;
          ne = ne + 1'b1;
        end
      end
      res = {s, ne, nm};
    end
  end

  generate
    if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_data  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_data <= res;
        end
      end

      // R10
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R10
      idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_data  = res;
    end
  endgenerate

  // R9
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_nan) |->
      (res[OW-2 -: EXP_W] == EALL && res[MAN_W-1] && res[OW-1] == s));
  // R11
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[30:0] == '0) |-> (res == {s, {(OW-1){1'b0}}}));
  // R3
  rtz_no_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rne_mode && se != 8'hFF && HAS_INF != 0) |->
      (res[OW-2:0] != {EALL, {MAN_W{1'b0}}}));
  // R8
  rtz_inf_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rne_mode && in_data[30:0] == 31'h7F800000 && HAS_INF != 0) |->
      (res[OW-2:0] == {EALL, {MAN_W{1'b0}}}));
endmodule

// File: tb/test_fp32_narrow.sv
module test_fp32_narrow;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        v;
    logic [15:0] eh;
    logic [7:0]  e8;
    string       tag;
    logic [31:0] x;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, rne = 1'b0;
  logic [31:0] in_data = '0;
  logic ov_h, ov_8;
  logic [15:0] od_h;
  logic [7:0]  od_8;
  int n_chk = 0, n_fail = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_narrow #(.EXP_W(5), .MAN_W(10), .HAS_INF(1), .REG_OUT(1)) i_fp32_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rne_mode(rne), .out_valid(ov_h), .out_data(od_h));

  fp32_narrow #(.EXP_W(4), .MAN_W(3), .HAS_INF(0), .REG_OUT(1)) i_fp32_narrow_e4m3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rne_mode(rne), .out_valid(ov_8), .out_data(od_8));

  function automatic logic [31:0] pk(logic s, int e, longint m, int te, int tm);
    return (32'(s) << (te + tm)) | (32'(e) << tm) | 32'(m);
  endfunction

  function automatic logic [31:0] ref_nar(logic [31:0] x, bit r, int te, int tm, bit inf);
    int bias = (1 << (te - 1)) - 1;
    int ef = (1 << te) - 1;
    longint mm = (64'sd1 << tm) - 1;
    int umax = inf ? bias : bias + 1;
    int umin = 1 - bias;
    logic s = x[31];
    int e = int'(x[30:23]);
    longint sig, kept, rem, q1;
    int unb, tex, drop, efield;
    if (e == 255) begin
      if (x[22:0] != 0)
        return inf ? pk(s, ef, longint'(x[22:0] >> (23 - tm)) | (64'sd1 << (tm - 1)), te, tm)
                   : pk(s, ef, mm, te, tm);
      if (inf) return pk(s, ef, 0, te, tm);
      return pk(s, ef, mm, te, tm);
    end
    if (x[30:0] == 0) return pk(s, 0, 0, te, tm);
    if (e == 0) begin
      if (umin + 126 > 23 - tm) return pk(s, 0, 0, te, tm);
      sig = longint'(x[22:0]);
      unb = -126;
    end else begin
      sig = longint'(x[22:0]) + (64'sd1 << 23);
      unb = e - 127;
    end
    if (unb > umax) begin
      if (r) return inf ? pk(s, ef, 0, te, tm) : pk(s, ef, mm, te, tm);
      return pk(s, inf ? ef - 1 : ef, mm, te, tm);
    end
    tex  = (unb < umin) ? umin : unb;
    drop = 23 - tm + tex - unb;
    if (drop > 24) return pk(s, 0, 0, te, tm);
    kept = sig >> drop;
    rem  = sig - (kept << drop);
    q1   = 64'sd1 << drop;
    if (r && (2*rem > q1 || (2*rem == q1 && kept[0]))) kept = kept + 1;
    if (kept >= (64'sd1 << (tm + 1))) begin
      efield = tex + bias;
      if (!inf && efield == ef) return pk(s, ef, mm, te, tm);
      return pk(s, efield + 1, 0, te, tm);
    end
    efield = (kept >= (64'sd1 << tm)) ? tex + bias : 0;
    return pk(s, efield, kept & mm, te, tm);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] x, bit r, string tag);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_data  = x;
    rne      = r;
    it.v   = v;
    it.x   = x;
    it.tag = tag;
    it.eh  = 16'(ref_nar(x, r, 5, 10, 1'b1));
    it.e8  = 8'(ref_nar(x, r, 4, 3, 1'b0));
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      // R10: valid follows one cycle later
      check(ov_h == it.v, "R10", "valid half", 32'(ov_h), 32'(it.v));
      check(ov_8 == it.v, "R10", "valid e4m3", 32'(ov_8), 32'(it.v));
      if (it.v) begin
        check(od_h == it.eh, it.tag, $sformatf("half in=%h", it.x), 32'(od_h), 32'(it.eh));
        check(od_8 == it.e8, it.tag, $sformatf("e4m3 in=%h", it.x), 32'(od_8), 32'(it.e8));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(ov_h == 1'b0 && od_h == '0, "R10", "reset half", {15'd0, ov_h, od_h}, 0);
    check(ov_8 == 1'b0 && od_8 == '0, "R10", "reset e4m3", {23'd0, ov_8, od_8}, 0);
    rst_n = 1'b1;
    // R11 zeros
    step(1, 32'h00000000, 1, "R11");
    step(1, 32'h80000000, 0, "R11");
    // R1 normals
    step(1, 32'h3F800000, 1, "R1");
    step(1, 32'hC0490FDB, 1, "R1");
    step(0, 32'h3F800000, 1, "R10");
    // R2 ties and above-half
    step(1, 32'h3F801000, 1, "R2");
    step(1, 32'h3F803000, 1, "R2");
    step(1, 32'h3F801001, 1, "R2");
    step(1, 32'h3F880000, 1, "R2");
    // R3 truncation
    step(1, 32'h3F803000, 0, "R3");
    step(1, 32'hBF9FFFFF, 0, "R3");
    step(1, 32'h477FF000, 0, "R3");
    // R4 carries
    step(1, 32'h477FF000, 1, "R4");
    step(1, 32'h43F80000, 1, "R4");
    step(1, 32'h43780000, 1, "R4");
    step(1, 32'h3FFFF000, 1, "R4");
    // R5 subnormal results
    step(1, 32'h35800000, 1, "R5");
    step(1, 32'h33C00000, 1, "R5");
    step(1, 32'h33000001, 1, "R5");
    step(1, 32'h387FF000, 1, "R5");
    step(1, 32'h3B000000, 1, "R5");
    step(1, 32'h3B100000, 0, "R5");
    // R6 signed zero
    step(1, 32'h33000000, 1, "R6");
    step(1, 32'hB0800000, 1, "R6");
    step(1, 32'h00000001, 1, "R6");
    step(1, 32'h80400000, 0, "R6");
    // R7 overflow, nearest
    step(1, 32'h49742400, 1, "R7");
    step(1, 32'hC9742400, 1, "R7");
    step(1, 32'h7F800000, 1, "R7");
    // R8 overflow, truncate
    step(1, 32'h49742400, 0, "R8");
    step(1, 32'hC9742400, 0, "R8");
    step(1, 32'hFF800000, 0, "R8");
    // R9 NaN
    step(1, 32'h7FC00000, 1, "R9");
    step(1, 32'h7F800001, 1, "R9");
    step(1, 32'hFFA00000, 0, "R9");
    step(1, 32'h7FAAAAAA, 1, "R9");
    // R1 random, full range and near target range
    for (int i = 0; i < 600; i++) begin
      logic [31:0] x;
      x = $urandom;
      if (i % 2 == 1) x[30:23] = 8'(90 + ($urandom % 70));
      step((i % 7) != 3, x, ($urandom % 2) == 1, "R1");
    end
    step(0, 0, 0, "R10");
    step(0, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule